// File: doc/BRIEF.md
# Checkerboard Memory Self-Test Engine

This block is a built-in self-test sequencer for a word-wide memory that is organised as a number of equal, fixed-size blocks. A start pulse begins the run. The engine first fills the whole memory with an alternating-bit word, one write per clock, at ascending addresses. It then walks back down from the highest address. At each word it reads the stored value and compares it with the fill word. It writes the bitwise complement into that word, reads it again and compares it with the complement.

The run ends at the first miscompare, or after the word at address zero has passed. The engine then raises a one-clock done pulse, with the pass/fail flag valid in the same cycle. A block code counts the blocks that have passed in full, so after a failure it shows how far the verify walk got. On a failure the engine also keeps the failing address, the data it read and the value it expected. All of these hold until the next start.

The memory is attached through a simple synchronous port. Read data is returned on the clock after the read request. Block size must be a power of two and at least 2. The block count may be any value of 1 or more.

Top module: `ckbd_bist`

## Requirements
- R1: After reset, busy, done and fail are 0, the block code and the capture outputs are 0, and the memory port is idle (memEn = 0, memWe = 0).
- R2: The fill phase writes the fill word into every address from 0 up to the last address, one write per clock and in ascending order. For 16-bit data the fill word is 0xAAAA: odd bit positions are 1 and even bit positions are 0.
- R3: The verify phase begins with a read of the highest address. Its read addresses never increase, and each first read of a word is compared with the fill word.
- R4: After a word matches the fill word, the complement is written into that word and read back. For 16-bit data the complement is 0x5555. After a fault-free run every word holds the complement.
- R5: The first miscompare in either comparison ends the run with fail = 1. The done pulse comes 2 clocks after the verify walk reaches the failing word for a failed first read, and 5 clocks after it for a failed complement read.
- R6: The block code goes up by one each time a whole block has passed both comparisons. It is NUM_BLKS after a passing run, and after a failure it is the number of blocks above the failing block.
- R7: On a failure, failAddr, failData and failExp hold the failing word address, the data read and the expected word. They stay unchanged until the next accepted start, which clears them and clears fail.
- R8: Read data is taken on the clock after the read request. A fault-free run of N words takes exactly 6·N clocks from the start edge to the done pulse.
- R9: A start pulse while busy is 1 has no effect on the sequence, the timing or the results.
- R10: Done is high for exactly one clock. In that clock busy is 0 and fail is valid, and a new start may be accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run; only accepted while busy is 0 |
| memEn | output | 1 | Memory access request |
| memWe | output | 1 | Write (1) or read (0) when memEn is 1 |
| memAddr | output | ADDR_W | Word address |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid one clock after a read request |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock end-of-run pulse |
| fail | output | 1 | Run ended on a miscompare |
| blkCode | output | CODE_W | Count of blocks that passed in full |
| failAddr | output | ADDR_W | Address of the failing word |
| failData | output | DATA_W | Data read at the failure |
| failExp | output | DATA_W | Expected data at the failure |

## Verification
Every result has a fixed arrival time. A passing run of N words ends 6·N clocks after the start edge. A failure at address a ends N + 5·(N−1−a) + 2 clocks after that edge for a bad first read, and 3 clocks later for a bad complement read. The bench counts clock edges from the start edge and samples on falling edges. It compares the edge count at which done rises with these formulas, and checks that done has fallen one falling edge later. The memory model returns read data one clock after the request and injects stuck bits at chosen addresses, so the expected failing address, data and block code follow from the fault placement alone.

// File: rtl/ckbd_bist_pkg.sv
package ckbd_bist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_RD_A,
    ST_CHK_A,
    ST_WR_B,
    ST_RD_B,
    ST_CHK_B
  } bistState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrRun;   // new run: clear address, code and captures
    logic incAddr;  // fill phase address step
    logic decAddr;  // verify phase address step
    logic memRd;    // issue read
    logic memWr;    // issue write
    logic wrComp;   // write data is the complement word
    logic expComp;  // comparison expects the complement word
    logic capFail;  // latch failure information
    logic incBlk;   // one more block passed
    logic finish;   // raise done next cycle
  } bistStrobe_t;

endpackage

// File: rtl/ckbd_bist_ctrl.sv
module ckbd_bist_ctrl
  import ckbd_bist_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        addrIsLast,
  input  logic        addrIsBase,
  input  logic        addrIsZero,
  input  logic        dataBad,
  output bistStrobe_t stb,
  output logic        busy
);

  bistState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.clrRun = 1'b1;
          stateNxt   = ST_FILL;
        end
      end
      ST_FILL: begin
        stb.memWr = 1'b1;
        if (addrIsLast) stateNxt = ST_RD_A;   // verify starts where fill ended
        else            stb.incAddr = 1'b1;
      end
      ST_RD_A: begin
        stb.memRd = 1'b1;
        stateNxt  = ST_CHK_A;
      end
      ST_CHK_A: begin
        if (dataBad) begin
          stb.capFail = 1'b1;
          stb.finish  = 1'b1;
          stateNxt    = ST_IDLE;
        end else begin
          stateNxt = ST_WR_B;
        end
      end
      ST_WR_B: begin
        stb.memWr  = 1'b1;
        stb.wrComp = 1'b1;
        stateNxt   = ST_RD_B;
      end
      ST_RD_B: begin
        stb.memRd = 1'b1;
        stateNxt  = ST_CHK_B;
      end
      ST_CHK_B: begin
        stb.expComp = 1'b1;
        if (dataBad) begin
          stb.capFail = 1'b1;
          stb.finish  = 1'b1;
          stateNxt    = ST_IDLE;
        end else begin
          stb.incBlk = addrIsBase;
          if (addrIsZero) begin
            stb.finish = 1'b1;
            stateNxt   = ST_IDLE;
          end else begin
            stb.decAddr = 1'b1;
            stateNxt    = ST_RD_A;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ckbd_bist_dp.sv
module ckbd_bist_dp
  import ckbd_bist_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BLK_WORDS = 4096,
  parameter int NUM_BLKS  = 4,
  localparam int TOTAL    = BLK_WORDS * NUM_BLKS,
  localparam int ADDR_W   = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int OFF_W    = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1,
  localparam int CODE_W   = $clog2(NUM_BLKS + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  bistStrobe_t       stb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              addrIsLast,
  output logic              addrIsBase,
  output logic              addrIsZero,
  output logic              dataBad,
  output logic [CODE_W-1:0] blkCode,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failData,
  output logic [DATA_W-1:0] failExp,
  output logic              done
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(TOTAL - 1);

  logic [DATA_W-1:0] patFill, patComp, expWord;
  logic [ADDR_W-1:0] addr;

  // Alternating word: odd bit positions set
  for (genvar i = 0; i < DATA_W; i++) begin : g_pat
    assign patFill[i] = ((i % 2) == 1);
  end
  assign patComp = ~patFill;

  assign expWord    = stb.expComp ? patComp : patFill;
  assign dataBad    = (memRdata != expWord);
  assign addrIsLast = (addr == LAST_ADDR);
  assign addrIsBase = (addr[OFF_W-1:0] == '0);
  assign addrIsZero = (addr == '0);
  assign memAddr    = addr;
  assign memWdata   = stb.wrComp ? patComp : patFill;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr <= '0;
    end else if (stb.clrRun) begin
      addr <= '0;
    end else if (stb.incAddr) begin
      addr <= addr + ADDR_W'(1);
    end else if (stb.decAddr) begin
      addr <= addr - ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkCode <= '0;
    end else if (stb.clrRun) begin
      blkCode <= '0;
    end else if (stb.incBlk) begin
      blkCode <= blkCode + CODE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fail     <= 1'b0;
      failAddr <= '0;
      failData <= '0;
      failExp  <= '0;
    end else if (stb.clrRun) begin
      fail     <= 1'b0;
      failAddr <= '0;
      failData <= '0;
      failExp  <= '0;
    end else if (stb.capFail) begin
      fail     <= 1'b1;
      failAddr <= addr;
      failData <= memRdata;
      failExp  <= expWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= stb.finish;
  end

endmodule

// File: rtl/ckbd_bist.sv
module ckbd_bist
  import ckbd_bist_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BLK_WORDS = 4096,
  parameter int NUM_BLKS  = 4,
  localparam int TOTAL    = BLK_WORDS * NUM_BLKS,
  localparam int ADDR_W   = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int CODE_W   = $clog2(NUM_BLKS + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [CODE_W-1:0] blkCode,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failData,
  output logic [DATA_W-1:0] failExp
);

  bistStrobe_t stb;
  logic addrIsLast, addrIsBase, addrIsZero, dataBad;

  ckbd_bist_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .addrIsLast (addrIsLast),
    .addrIsBase (addrIsBase),
    .addrIsZero (addrIsZero),
    .dataBad    (dataBad),
    .stb        (stb),
    .busy       (busy)
  );

  ckbd_bist_dp #(
    .DATA_W    (DATA_W),
    .BLK_WORDS (BLK_WORDS),
    .NUM_BLKS  (NUM_BLKS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .addrIsLast (addrIsLast),
    .addrIsBase (addrIsBase),
    .addrIsZero (addrIsZero),
    .dataBad    (dataBad),
    .blkCode    (blkCode),
    .fail       (fail),
    .failAddr   (failAddr),
    .failData   (failData),
    .failExp    (failExp),
    .done       (done)
  );

  assign memEn = stb.memRd | stb.memWr;
  assign memWe = stb.memWr;

endmodule

// File: rtl/ckbd_bist_chk.sv
module ckbd_bist_chk #(
  parameter int ADDR_W   = 14,
  parameter int CODE_W   = 3,
  parameter int NUM_BLKS = 4
)(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [CODE_W-1:0] blkCode,
  input logic [ADDR_W-1:0] failAddr,
  input logic              memEn,
  input logic              memWe
);

  AST_RESET_IDLE: assert property (@(posedge clk) !rstN |-> (!done && !fail && !memEn)); // R1

  AST_WE_WITH_EN: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn); // R2

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memEn); // R3

  AST_CODE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    blkCode <= CODE_W'(NUM_BLKS)); // R6

  AST_CODE_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (blkCode >= $past(blkCode))); // R6

  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(fail) && $stable(failAddr))); // R7

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && !fail && blkCode == '0)); // R7

  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R10

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy)); // R10

endmodule

bind ckbd_bist ckbd_bist_chk #(
  .ADDR_W   (ADDR_W),
  .CODE_W   (CODE_W),
  .NUM_BLKS (NUM_BLKS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .fail     (fail),
  .blkCode  (blkCode),
  .failAddr (failAddr),
  .memEn    (memEn),
  .memWe    (memWe)
);

// File: tb/ckbd_bist_bench.sv
module ckbd_bist_bench;

  localparam int DW  = 16;
  localparam int BW  = 8;
  localparam int NB  = 4;
  localparam int N   = BW * NB;
  localparam int AW  = 5;
  localparam int CW  = 3;
  localparam logic [DW-1:0] PAT_A = 16'hAAAA;
  localparam logic [DW-1:0] PAT_B = 16'h5555;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata = '0;
  logic          busy, done, fail;
  logic [CW-1:0] blkCode;
  logic [AW-1:0] failAddr;
  logic [DW-1:0] failData, failExp;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;   // 250 MHz

  ckbd_bist #(.DATA_W(DW), .BLK_WORDS(BW), .NUM_BLKS(NB)) u_ckbd_bist (
    .clk(clk), .rstN(rstN), .start(start),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .done(done), .fail(fail), .blkCode(blkCode),
    .failAddr(failAddr), .failData(failData), .failExp(failExp)
  );

  // Memory model: one-clock read latency, optional stuck bits at one address
  logic [DW-1:0] mem [N];
  bit            faultOn   = 1'b0;
  logic [AW-1:0] faultAddr = '0;
  logic [DW-1:0] faultMask = '0;
  logic [DW-1:0] faultVal  = '0;
  bit            clrMon    = 1'b0;
  int            wrCount   = 0;
  int            rdCount   = 0;
  logic [AW-1:0] lastRd    = '0;
  bit            fillBad   = 1'b0;
  bit            vrfBad    = 1'b0;

  function automatic logic [DW-1:0] faultRead(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    v = mem[a];
    if (faultOn && a == faultAddr) v = (v & ~faultMask) | (faultVal & faultMask);
    return v;
  endfunction

  always @(posedge clk) begin
    if (clrMon) begin
      wrCount <= 0; rdCount <= 0; fillBad <= 1'b0; vrfBad <= 1'b0;
    end else begin
      if (memEn && memWe) begin
        mem[memAddr] <= memWdata;
        if (wrCount < N && (int'(memAddr) != wrCount || memWdata != PAT_A)) fillBad <= 1'b1;
        wrCount <= wrCount + 1;
      end
      if (memEn && !memWe) begin
        memRdata <= faultRead(memAddr);
        if (rdCount == 0 && int'(memAddr) != N - 1) vrfBad <= 1'b1;
        if (rdCount != 0 && memAddr > lastRd) vrfBad <= 1'b1;
        lastRd  <= memAddr;
        rdCount <= rdCount + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Runs the engine; returns edge count from start edge to done (0 on timeout)
  task automatic runBist(input bit busyStarts, output int cyc);
    int cnt;
    @(negedge clk); clrMon = 1'b1;
    @(negedge clk); clrMon = 1'b0; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    cnt = 0;
    while (!done && cnt < 2000) begin
      @(negedge clk);
      cnt++;
      start = busyStarts && (cnt == 40 || cnt == 100);
    end
    start = 1'b0;
    if (!done) begin
      check(1'b0, "R10", "watchdog: done never seen", 32'(cnt), 32'(6 * N));
      cyc = 0;
    end else begin
      cyc = cnt;
      check(!busy, "R10", "busy during done", 32'(busy), 32'd0);
      @(negedge clk);
      check(!done, "R10", "done longer than one clock", 32'(done), 32'd0);
    end
  endtask

  task automatic testReset();
    check(!busy && !done && !fail, "R1", "busy/done/fail after reset",
          {29'd0, busy, done, fail}, 32'd0);
    check(blkCode == '0 && failAddr == '0, "R1", "code/addr after reset",
          {24'd0, blkCode, failAddr}, 32'd0);
    check(failData == '0 && failExp == '0, "R1", "capture data after reset",
          {failData, failExp}, 32'd0);
    check(!memEn && !memWe, "R1", "memory port after reset", {30'd0, memEn, memWe}, 32'd0);
  endtask

  task automatic testPass(input bit busyStarts, input string req);
    int cyc;
    bit allComp;
    faultOn = 1'b0;
    runBist(busyStarts, cyc);
    check(cyc == 6 * N, req, "pass run length (R8)", 32'(cyc), 32'(6 * N));
    check(!fail, req, "fail on clean run", 32'(fail), 32'd0);
    check(blkCode == CW'(NB), "R6", "block code after pass", 32'(blkCode), 32'(NB));
    check(!fillBad && wrCount == 2 * N, "R2", "ascending fill with 0xAAAA", 32'(wrCount), 32'(2 * N));
    check(!vrfBad && rdCount == 2 * N, "R3", "descending verify from top", 32'(rdCount), 32'(2 * N));
    allComp = 1'b1;
    for (int i = 0; i < N; i++) if (mem[i] != PAT_B) allComp = 1'b0;
    check(allComp, "R4", "memory holds 0x5555 after run", 32'(allComp), 32'd1);
  endtask

  task automatic testFault(input int a, input logic [DW-1:0] mask, input logic [DW-1:0] val,
                           input bit second, input logic [DW-1:0] expData,
                           input string req);
    int cyc, expCyc;
    faultOn = 1'b1; faultAddr = AW'(a); faultMask = mask; faultVal = val;
    expCyc = N + 5 * (N - 1 - a) + (second ? 5 : 2);
    runBist(1'b0, cyc);
    check(cyc == expCyc, "R5", "cycles to failure", 32'(cyc), 32'(expCyc));
    check(fail, "R5", "fail flag", 32'(fail), 32'd1);
    check(failAddr == AW'(a), "R7", "failing address", 32'(failAddr), 32'(a));
    check(failData == expData, req, "failing data", 32'(failData), 32'(expData));
    check(failExp == (second ? PAT_B : PAT_A), req, "expected word",
          32'(failExp), 32'(second ? PAT_B : PAT_A));
    check(blkCode == CW'(NB - 1 - a / BW), "R6", "block code at failure",
          32'(blkCode), 32'(NB - 1 - a / BW));
    faultOn = 1'b0;
  endtask

  task automatic testHold();
    logic [AW-1:0] a0 = failAddr;
    logic [DW-1:0] d0 = failData;
    repeat (20) @(negedge clk);
    check(fail && failAddr == a0 && failData == d0, "R7", "capture held while idle",
          {11'd0, fail, failAddr, d0}, {11'd0, 1'b1, a0, d0});
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!fail && failAddr == '0 && failData == '0, "R7", "capture cleared by start",
          {11'd0, fail, failAddr, failData}, 32'd0);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "R10", "global watchdog", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();                                         // R1
    rstN = 1'b1;
    @(negedge clk);
    testReset();                                         // R1
    testPass(1'b0, "R10");                               // R2 R3 R4 R6 R8 R10
    testFault(13, 16'h0001, 16'h0001, 1'b0, 16'hAAAB, "R3"); // stuck-1 on first read
    testHold();                                          // R7
    testFault(31, 16'h8000, 16'h8000, 1'b1, 16'hD555, "R4"); // complement read fails
    testFault(0, 16'h0002, 16'h0000, 1'b0, 16'hAAA8, "R5");  // lowest word fails
    testPass(1'b1, "R9");                                // starts while busy ignored
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule